// File: doc/BRIEF.md
# ADC Serial Result Output Port

This block is the readout side of a 14-bit successive-approximation converter. A behavioural conversion core holds a busy flag for sixteen conversion-clock periods after an accepted start request. When that period ends it hands the result word to a 16-bit output shift register as the word followed by two zero bits. The most significant bit is placed on the data line at once. Each falling edge of the selected serial clock then advances the line by one bit, so every bit stays steady from one rising edge through the following falling edge. A receiver may therefore capture on either edge.

The serial clock is either an external data clock or the core's own conversion clock, which is also driven out of the block. All clocks are sampled and edge-detected in the system clock domain. A high read input discards serial clock edges and disables the output driver. A high chip select also disables the driver and rejects start requests. The active-low busy output can be looped back to the read input. In that case the previous result streams out during a conversion on the conversion clock, and the port goes quiet once the new word is loaded.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the shift register is all zeros, so `dout` is 0, `busy_n` is 1 and `clk_out` is 0.
- R2: In the cycle `busy_n` returns high, the register holds `{result_in, 2'b00}` and `dout` shows `result_in[13]`.
- R3: A falling edge of the selected serial clock, seen as high then low at two consecutive system clock edges, shifts the register left by one with a zero fed in. `dout` changes at the second of those edges. Rising edges change nothing.
- R4: After 14 data bits have been shifted out, `dout` is 0 for the 15th, 16th and every further falling edge, until a new word is loaded.
- R5: While `rd` is 1, serial clock falling edges have no effect on the shifted data.
- R6: While `cs` is 1, a `conv_start` request is ignored and `busy_n` stays 1.
- R7: `dout_oe` is 1 exactly when `rd` is 0 and `cs` is 0.
- R8: An accepted start (`busy_n` high, `cs` low) drives `busy_n` low at the next edge. The conversion ends at the 16th falling edge of `clk_out` counted from then. A start while busy is ignored.
- R9: With `int_clk_sel` 1 the serial clock is the conversion clock `clk_out` and `ext_sclk` has no effect. With `int_clk_sel` 0 the serial clock is `ext_sclk`.
- R10: When a load and a serial falling edge occur in the same cycle, the load wins, and `dout` shows the new word's MSB unshifted.
- R11: Data shifted out during a conversion is the previous conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sclk | input | 1 | External serial data clock |
| int_clk_sel | input | 1 | 1 selects the conversion clock as the serial clock |
| rd | input | 1 | Read gate, high ignores the serial clock and disables the driver |
| cs | input | 1 | Chip select, high disables the driver and blocks starts |
| conv_start | input | 1 | Conversion start request |
| result_in | input | 14 | Result word taken at end of conversion |
| clk_out | output | 1 | Conversion clock level |
| busy_n | output | 1 | Low while a conversion runs |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output driver enable for `dout` |

## Verification
The end-of-conversion load and a serial shift can land in the same cycle. This always happens in internal-clock mode with `busy_n` looped to `rd`, because the conversion-clock fall that ends the conversion is also a serial edge. The bench runs several conversions in that mode and counts the cycles where a load coincides with a sampled fall while read is low. It requires at least one such cycle, and in each one `dout` must equal the new word's MSB rather than a shifted bit.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
    localparam int unsigned WORD_W     = 14;
    localparam int unsigned FRAME_W    = 16;
    localparam int unsigned CONV_EDGES = 16;
    localparam int unsigned CONV_DIV   = 2;
endpackage

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
    parameter int unsigned DIV        = adc_ser_pkg::CONV_DIV,
    parameter int unsigned CONV_EDGES = adc_ser_pkg::CONV_EDGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cs,
    output logic clk_lvl,
    output logic busy,
    output logic eoc
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned EW = (CONV_EDGES > 1) ? $clog2(CONV_EDGES) : 1;

    typedef struct packed {
        logic [CW-1:0] div_cnt;
        logic          lvl;
        logic          prev;
        logic          busy;
        logic [EW-1:0] edges;
    } conv_state_t;

    conv_state_t st_d, st_q;
    logic        fall;
    logic        eoc_c;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev & ~st_q.lvl;
        st_d.prev = st_q.lvl;
        if (st_q.div_cnt == CW'(DIV - 1)) begin
            st_d.div_cnt = '0;
            st_d.lvl     = ~st_q.lvl;
        end else begin
            st_d.div_cnt = st_q.div_cnt + 1'b1;
        end
        eoc_c = st_q.busy & fall & (st_q.edges == EW'(CONV_EDGES - 1));
        if (st_q.busy && fall) begin
            if (eoc_c) begin
                st_d.busy  = 1'b0;
                st_d.edges = '0;
            end else begin
                st_d.edges = st_q.edges + 1'b1;
            end
        end
        if (!st_q.busy && start && !cs) begin
            st_d.busy  = 1'b1;
            st_d.edges = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_lvl = st_q.lvl;
    assign busy    = st_q.busy;
    assign eoc     = eoc_c;

    // R6
    cs_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && cs) |=> !st_q.busy);
    // R8
    start_begins_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start && !cs) |=> (st_q.busy && st_q.edges == '0));
    // R8
    eoc_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !st_q.busy);
    // R8
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.edges) < int'(CONV_EDGES)));
endmodule

// File: rtl/adc_sclk_gate.sv
module adc_sclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sclk,
    input  logic int_lvl,
    input  logic int_sel,
    input  logic rd,
    output logic shift_fall
);
    typedef struct packed {
        logic prev;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        lvl;

    always_comb begin
        lvl        = int_sel ? int_lvl : ext_sclk;
        st_d       = st_q;
        st_d.prev  = lvl;
        shift_fall = st_q.prev & ~lvl & ~rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    rd_gates_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !shift_fall);
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
    parameter int unsigned WORD_W  = adc_ser_pkg::WORD_W,
    parameter int unsigned FRAME_W = adc_ser_pkg::FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              msb
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shift_state_t;

    shift_state_t       st_d, st_q;
    logic [FRAME_W-1:0] framed;

    generate
        if (FRAME_W > WORD_W) begin : g_pad
            assign framed = {word, {(FRAME_W - WORD_W){1'b0}}};
        end else begin : g_trim
            assign framed = word[WORD_W-1 -: FRAME_W];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load)       st_d.sr = framed;
        else if (shift) st_d.sr = {st_q.sr[FRAME_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb = st_q.sr[FRAME_W-1];

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.sr == $past(framed)));
    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (st_q.sr == {$past(st_q.sr[FRAME_W-2:0]), 1'b0}));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load) |=> $stable(st_q.sr));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int unsigned WORD_W     = adc_ser_pkg::WORD_W,
    parameter int unsigned FRAME_W    = adc_ser_pkg::FRAME_W,
    parameter int unsigned CONV_EDGES = adc_ser_pkg::CONV_EDGES,
    parameter int unsigned CONV_DIV   = adc_ser_pkg::CONV_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sclk,
    input  logic              int_clk_sel,
    input  logic              rd,
    input  logic              cs,
    input  logic              conv_start,
    input  logic [WORD_W-1:0] result_in,
    output logic              clk_out,
    output logic              busy_n,
    output logic              dout,
    output logic              dout_oe
);
    logic conv_lvl;
    logic conv_busy;
    logic conv_eoc;
    logic shift_fall;

    adc_conv_model #(.DIV(CONV_DIV), .CONV_EDGES(CONV_EDGES)) i_conv (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .cs(cs),
        .clk_lvl(conv_lvl), .busy(conv_busy), .eoc(conv_eoc)
    );

    adc_sclk_gate i_gate (
        .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .int_lvl(conv_lvl),
        .int_sel(int_clk_sel), .rd(rd), .shift_fall(shift_fall)
    );

    adc_shift_out #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(conv_eoc), .word(result_in),
        .shift(shift_fall), .msb(dout)
    );

    assign clk_out = conv_lvl;
    assign busy_n  = ~conv_busy;
    assign dout_oe = ~rd & ~cs;

    // R2
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_eoc |=> (busy_n && dout == $past(result_in[WORD_W-1])));
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_sclk = 1'b0;
    logic        int_clk_sel = 1'b0;
    logic        rd = 1'b1;
    logic        cs = 1'b0;
    logic        conv_start = 1'b0;
    logic [13:0] result_in = '0;
    logic        clk_out, busy_n, dout, dout_oe;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   collide = 0;
    bit   tie_rd = 1'b0;
    bit   finished = 1'b0;

    logic [15:0] exp_sr = '0;
    logic prev_lvl = 1'b0, co_m1 = 1'b0, co_m2 = 1'b0, busy_last = 1'b1;
    int   nshift = 0;
    int   edges = 0;

    always #10 clk = ~clk;

    adc_serial_port i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .int_clk_sel(int_clk_sel),
        .rd(rd), .cs(cs), .conv_start(conv_start), .result_in(result_in),
        .clk_out(clk_out), .busy_n(busy_n), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic string dout_tag(input bit eoc, input bit fall, input bit rdv);
        if (eoc && fall && !rdv) return "R10";
        if (eoc)                 return "R2";
        if (fall && rdv)         return "R5";
        if (int_clk_sel && !busy_last) return "R11";
        if (int_clk_sel)         return "R9";
        if (nshift >= 14)        return "R4";
        return "R3";
    endfunction

    // reference model, evaluated just after each active edge
    always @(posedge clk) begin
        bit lvl, fall, cfall, eoc;
        #2;
        if (!rst_n) begin
            exp_sr = '0; prev_lvl = 0; co_m1 = 0; co_m2 = 0; busy_last = 1; nshift = 0; edges = 0;
        end else begin
            lvl   = int_clk_sel ? co_m1 : ext_sclk;
            fall  = prev_lvl && !lvl;
            cfall = co_m2 && !co_m1;
            eoc   = busy_n && !busy_last;
            if (!busy_last && cfall) edges++;
            if (eoc) check(edges == 16, "R8", "conversion clock falls", edges, 16);
            if (busy_last && !busy_n) edges = 0;
            if (eoc) begin
                if (fall && !rd) collide++;
                exp_sr = {result_in, 2'b00};
                nshift = 0;
            end else if (fall && !rd) begin
                exp_sr = {exp_sr[14:0], 1'b0};
                nshift++;
            end
            check(dout === exp_sr[15], dout_tag(eoc, fall, rd), "dout", dout, exp_sr[15]);
            check(dout_oe === (!rd && !cs), "R7", "dout_oe", dout_oe, !rd && !cs);
            prev_lvl  = lvl;
            co_m2     = co_m1;
            co_m1     = clk_out;
            busy_last = busy_n;
        end
    end

    always @(negedge clk) if (tie_rd) rd = busy_n;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_up();
        end
    end

    task automatic run_conv(input logic [13:0] v);
        int n = 0;
        @(negedge clk);
        result_in  = v;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        check(busy_n === 1'b0, "R8", "busy_n after start", busy_n, 0);
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        while (busy_n !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(busy_n === 1'b1, "R8", "conversion ended", busy_n, 1);
    endtask

    task automatic ext_frame(input int n, input bit rnd_rd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rnd_rd) rd = ($urandom % 6) == 0;
            ext_sclk = 1'b1;
            repeat ($urandom % 3) @(negedge clk);
            @(negedge clk);
            ext_sclk = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
        end
        @(negedge clk);
        if (rnd_rd) rd = 1'b0;
    endtask

    initial begin
        logic [13:0] v;
        void'($urandom(32'd1418));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dout === 1'b0, "R1", "dout after reset", dout, 0);
        check(busy_n === 1'b1, "R1", "busy_n after reset", busy_n, 1);
        check(clk_out === 1'b0 || clk_out === 1'b1, "R1", "clk_out known", clk_out, 0);

        // R6 chip select blocks conversions and the driver
        cs = 1'b1; rd = 1'b0;
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy_n === 1'b1, "R6", "start ignored with cs high", busy_n, 1);
        check(dout_oe === 1'b0, "R6", "driver off with cs high", dout_oe, 0);
        cs = 1'b0;

        // R2 load and MSB
        run_conv(14'h2A5C);
        check(dout === 1'b1, "R2", "MSB after load", dout, 1);
        // R4 long frame of 20 falls
        ext_frame(20, 1'b0);
        check(dout === 1'b0, "R4", "zeros after 14 bits", dout, 0);

        // R5 read high ignores edges
        run_conv(14'h2000);
        rd = 1'b1;
        ext_frame(4, 1'b0);
        rd = 1'b0;
        @(negedge clk);
        check(dout === 1'b1, "R5", "MSB held while rd high", dout, 1);

        // random external-clock frames
        for (int k = 0; k < 15; k++) begin
            v = 14'($urandom);
            if ($urandom % 3 == 0) begin
                cs = 1'b1;
                @(negedge clk); conv_start = 1'b1;
                @(negedge clk); conv_start = 1'b0; cs = 1'b0;
                check(busy_n === 1'b1, "R6", "blocked start", busy_n, 1);
            end
            run_conv(v);
            check(dout === v[13], "R2", "loaded MSB", dout, v[13]);
            ext_frame(14 + int'($urandom % 7), 1'b1);
        end

        // internal clock, busy looped to read, external clock noise
        int_clk_sel = 1'b1;
        tie_rd = 1'b1;
        for (int k = 0; k < 8; k++) begin
            v = 14'($urandom);
            fork
                run_conv(v);
                repeat (40) begin
                    @(negedge clk);
                    ext_sclk = ~ext_sclk;
                end
            join
            check(dout === v[13], "R11", "new MSB after internal frame", dout, v[13]);
        end
        check(collide > 0, "R10", "load and shift collisions seen", collide, 1);
        tie_rd = 1'b0;

        // R9 internal clock free-running with rd low shifts out to zero
        rd = 1'b0;
        repeat (80) @(negedge clk);
        check(dout === 1'b0, "R9", "internal clock drained word", dout, 0);
        int_clk_sel = 1'b0;
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule